// File: doc/BRIEF.md
# Prioritised Interrupt Level Encoder and Acknowledger

This block sits between seven active-low interrupt request lines and a processor core. It reduces the request lines to a 3-bit priority level and compares that level with the core's current interrupt mask. When a request is accepted, it runs an interrupt-acknowledge bus cycle. During that cycle it drives the acknowledge function code and presents the level being served on address bits 3:1.

The acknowledge cycle ends in one of three ways. In the first, a peripheral returns its own vector on the data bus together with a data-acknowledge strobe. In the second, a simple peripheral asks for an automatic vector. In the third, nothing answers and a timeout produces the spurious-interrupt vector. At the end the block reports the vector number and its table byte address, which is the vector times four. When the request is accepted it also gives the core a new mask value and a set supervisor flag to load.

Stacking of state, instruction sequencing and reading the vector table stay in the core. This block only decides which level is served and which vector applies.

Top module: `irq_level_ack`

## Requirements
- R1: Request bit i of `irq_n` (active low) stands for level i+1. The encoded level is the highest active bit. With no bit low the level is 0, no acknowledge starts, and `fc_o` stays 000.
- R2: When idle, a level is accepted only if it is strictly greater than `mask_i`. Level 7 is accepted whatever the mask holds.
- R3: One cycle after the accepting edge, `sr_wr_o` is high for exactly one cycle, with `sr_mask_o` equal to the accepted level and `sr_super_o` = 1.
- R4: For the whole acknowledge cycle, `fc_o` = 111 and `addr_o` (address bits 3:1) carries the accepted level. Outside it, both are 0.
- R5: If `dtack_n` is low at an edge during the acknowledge, the vector is `data_i[7:0]` and `vec_addr_o` is that vector shifted left by two bits.
- R6: If `vpa_n` is low (and `dtack_n` high) at an edge during the acknowledge, the vector is 24 plus the level, which gives 25 to 31.
- R7: If neither strobe is seen for TIMEOUT acknowledge cycles, the acknowledge ends with vector 24 (spurious). The number of cycles with `fc_o` = 111 is then exactly TIMEOUT.
- R8: When `dtack_n` and `vpa_n` are both low at the same edge, the data vector is used.
- R9: Changes on `irq_n` and `mask_i` during an acknowledge have no effect: `addr_o` holds the accepted level until the end.
- R10: `done_o` is high for one cycle, in the cycle after the resolving edge. `fc_o` has returned to 000 in that cycle, and `vec_o` and `vec_addr_o` are valid in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 7 | Interrupt requests, active low, bit i = level i+1 |
| mask_i | input | 3 | Current interrupt mask from the status register |
| dtack_n | input | 1 | Data acknowledge, active low: vector valid on data_i |
| vpa_n | input | 1 | Automatic vector request, active low |
| data_i | input | 8 | Vector number from the peripheral |
| fc_o | output | 3 | Function code, 111 during acknowledge |
| addr_o | output | 3 | Address bits 3:1, level under acknowledge |
| sr_wr_o | output | 1 | Status register update strobe |
| sr_mask_o | output | 3 | New mask value |
| sr_super_o | output | 1 | New supervisor flag |
| done_o | output | 1 | Acknowledge finished, vector valid |
| vec_o | output | 8 | Resolved vector number |
| vec_addr_o | output | 10 | Vector table byte address |

## Verification
There are two places where functions of this block can meet in one cycle.

The first is the two response strobes arriving together. The bench provokes this by pulling both `dtack_n` and `vpa_n` low at the same negative edge, both in a directed case and among random cases. The outcome passes only if the peripheral's data vector is reported rather than 24 plus the level.

The second is a strobe arriving on the last cycle the timeout would allow. The bench holds the bus silent for TIMEOUT-1 cycles and then returns data. It expects the data vector, not the spurious vector, and it expects the acknowledge length to be exactly TIMEOUT cycles.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  localparam int NUM_LVL   = 7;
  localparam int LVL_W     = 3;
  localparam int VEC_W     = 8;
  localparam int FC_W      = 3;
  localparam logic [FC_W-1:0]  FC_IACK   = 3'b111;
  localparam logic [FC_W-1:0]  FC_IDLE   = 3'b000;
  localparam logic [VEC_W-1:0] AUTO_BASE = 8'd24;
  localparam logic [VEC_W-1:0] SPUR_VEC  = 8'd24;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_ACK  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/irqa_prio_enc.sv
module irqa_prio_enc #(
  parameter int NLVL = 7,
  parameter int LW   = 3
) (
  input  logic [NLVL-1:0] req_n,
  output logic [LW-1:0]   level
);
  logic [NLVL-1:0] act;
  logic [NLVL-1:0] win;
  logic [NLVL:0]   above;

  assign act         = ~req_n;
  assign above[NLVL] = 1'b0;

  genvar g;
  generate
    for (g = NLVL - 1; g >= 0; g--) begin : g_chain
      assign win[g]   = act[g] & ~above[g+1];
      assign above[g] = above[g+1] | act[g];
    end
  endgenerate

  always_comb begin
    level = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (win[i]) level = level | LW'(i + 1);
    end
  end
endmodule

// File: rtl/irqa_take_gate.sv
module irqa_take_gate #(
  parameter int NLVL = 7,
  parameter int LW   = 3
) (
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] mask,
  output logic          take
);
  localparam logic [LW-1:0] NMI_LVL = LW'(NLVL);

  logic pending;
  logic above_mask;
  logic non_maskable;

  always_comb begin
    pending      = (level != '0);
    above_mask   = (level > mask);
    non_maskable = (level == NMI_LVL);
    take         = pending & (above_mask | non_maskable);
  end
endmodule

// File: rtl/irqa_ack_seq.sv
module irqa_ack_seq
  import irqa_pkg::*;
#(
  parameter int TIMEOUT = 64,
  parameter int LW      = 3,
  parameter int VW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [LW-1:0] level_i,
  input  logic          dtack_n,
  input  logic          vpa_n,
  input  logic [VW-1:0] data_i,
  output logic [2:0]    fc_o,
  output logic [LW-1:0] addr_o,
  output logic          sr_wr_o,
  output logic [LW-1:0] sr_mask_o,
  output logic          sr_super_o,
  output logic          done_o,
  output logic [VW-1:0] vec_o,
  output logic [VW+1:0] vec_addr_o
);
  localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  seq_state_t      state_q, state_d;
  logic [LW-1:0]   lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [VW-1:0]   vec_q, vec_d;
  logic            done_q, done_d;
  logic            srwr_q, srwr_d;
  logic            lvl_en, vec_en, cnt_en;

  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    cnt_d   = cnt_q;
    vec_d   = vec_q;
    done_d  = 1'b0;
    srwr_d  = 1'b0;
    lvl_en  = 1'b0;
    vec_en  = 1'b0;
    cnt_en  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (take_i) begin
          state_d = SEQ_ACK;
          lvl_d   = level_i;
          lvl_en  = 1'b1;
          cnt_d   = '0;
          cnt_en  = 1'b1;
          srwr_d  = 1'b1;
        end
      end
      SEQ_ACK: begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
        if (!dtack_n) begin
          vec_d   = data_i;
          vec_en  = 1'b1;
          done_d  = 1'b1;
          state_d = SEQ_IDLE;
        end else if (!vpa_n) begin
          vec_d   = AUTO_BASE + VW'(lvl_q);
          vec_en  = 1'b1;
          done_d  = 1'b1;
          state_d = SEQ_IDLE;
        end else if (cnt_q == CNT_LAST) begin
          vec_d   = SPUR_VEC;
          vec_en  = 1'b1;
          done_d  = 1'b1;
          state_d = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
      srwr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      srwr_q  <= srwr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (lvl_en) begin
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (vec_en) begin
      vec_q <= vec_d;
    end
  end

  assign fc_o       = (state_q == SEQ_ACK) ? FC_IACK : FC_IDLE;
  assign addr_o     = (state_q == SEQ_ACK) ? lvl_q : '0;
  assign sr_wr_o    = srwr_q;
  assign sr_mask_o  = lvl_q;
  assign sr_super_o = srwr_q;
  assign done_o     = done_q;
  assign vec_o      = vec_q;
  assign vec_addr_o = {vec_q, 2'b00};
endmodule

// File: rtl/irq_level_ack.sv
module irq_level_ack
  import irqa_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LVL-1:0]   irq_n,
  input  logic [LVL_W-1:0]     mask_i,
  input  logic                 dtack_n,
  input  logic                 vpa_n,
  input  logic [VEC_W-1:0]     data_i,
  output logic [FC_W-1:0]      fc_o,
  output logic [LVL_W-1:0]     addr_o,
  output logic                 sr_wr_o,
  output logic [LVL_W-1:0]     sr_mask_o,
  output logic                 sr_super_o,
  output logic                 done_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic [VEC_W+1:0]     vec_addr_o
);
  logic [LVL_W-1:0] level;
  logic             take;

  irqa_prio_enc #(.NLVL(NUM_LVL), .LW(LVL_W)) u_enc (
    .req_n (irq_n),
    .level (level)
  );

  irqa_take_gate #(.NLVL(NUM_LVL), .LW(LVL_W)) u_gate (
    .level (level),
    .mask  (mask_i),
    .take  (take)
  );

  irqa_ack_seq #(.TIMEOUT(TIMEOUT), .LW(LVL_W), .VW(VEC_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take),
    .level_i    (level),
    .dtack_n    (dtack_n),
    .vpa_n      (vpa_n),
    .data_i     (data_i),
    .fc_o       (fc_o),
    .addr_o     (addr_o),
    .sr_wr_o    (sr_wr_o),
    .sr_mask_o  (sr_mask_o),
    .sr_super_o (sr_super_o),
    .done_o     (done_o),
    .vec_o      (vec_o),
    .vec_addr_o (vec_addr_o)
  );
endmodule

// File: rtl/irq_level_ack_checker.sv
module irq_level_ack_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] irq_n,
  input logic       dtack_n,
  input logic       vpa_n,
  input logic [7:0] data_i,
  input logic [2:0] fc_o,
  input logic [2:0] addr_o,
  input logic       sr_wr_o,
  input logic [2:0] sr_mask_o,
  input logic       sr_super_o,
  input logic       done_o,
  input logic [7:0] vec_o
);
  AST_IACK_HAS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_o == 3'b111) |-> (addr_o != 3'd0)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_o == 3'b000) |-> (addr_o == 3'd0)); // R4

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_o == 3'b111 && $past(fc_o) == 3'b111) |-> $stable(addr_o)); // R9

  AST_SR_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_o |-> (sr_super_o && fc_o == 3'b111 && sr_mask_o == addr_o)); // R3

  AST_SR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_o |=> !sr_wr_o); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_DONE_ENDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (fc_o == 3'b000 && $past(fc_o) == 3'b111)); // R10

  AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_o == 3'b000 && !irq_n[6]) |=> (fc_o == 3'b111 && addr_o == 3'd7)); // R2

  AST_DTACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(dtack_n)) |-> (vec_o == $past(data_i))); // R8

  AST_AUTOVEC: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(dtack_n) && !$past(vpa_n)) |-> (vec_o == 8'd24 + {5'd0, $past(addr_o)})); // R6
endmodule

bind irq_level_ack irq_level_ack_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_n      (irq_n),
  .dtack_n    (dtack_n),
  .vpa_n      (vpa_n),
  .data_i     (data_i),
  .fc_o       (fc_o),
  .addr_o     (addr_o),
  .sr_wr_o    (sr_wr_o),
  .sr_mask_o  (sr_mask_o),
  .sr_super_o (sr_super_o),
  .done_o     (done_o),
  .vec_o      (vec_o)
);

// File: tb/irq_level_ack_bench.sv
`timescale 1ns/1ps
module irq_level_ack_bench;
  localparam int TMO = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] irq_n;
  logic [2:0] mask_i;
  logic       dtack_n, vpa_n;
  logic [7:0] data_i;
  logic [2:0] fc_o, addr_o, sr_mask_o;
  logic       sr_wr_o, sr_super_o, done_o;
  logic [7:0] vec_o;
  logic [9:0] vec_addr_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  irq_level_ack #(.TIMEOUT(TMO)) u_irq_level_ack (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .mask_i(mask_i),
    .dtack_n(dtack_n), .vpa_n(vpa_n), .data_i(data_i),
    .fc_o(fc_o), .addr_o(addr_o), .sr_wr_o(sr_wr_o), .sr_mask_o(sr_mask_o),
    .sr_super_o(sr_super_o), .done_o(done_o), .vec_o(vec_o), .vec_addr_o(vec_addr_o)
  );

  function automatic logic [2:0] top_level(input logic [6:0] rq_n);
    logic [2:0] l = 3'd0;
    for (int i = 0; i < 7; i++) if (!rq_n[i]) l = 3'(i + 1);
    return l;
  endfunction

  function automatic bit accepts(input logic [2:0] l, input logic [2:0] m);
    return (l != 0) && ((l == 3'd7) || (l > m));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 data strobe, 1 auto vector, 2 both together, 3 silent (timeout)
  // delay: idle bus cycles before the strobe
  task automatic run_case(input logic [6:0] rq, input logic [2:0] m, input int kind,
                          input int delay, input logic [7:0] dv);
    logic [2:0] lvl;
    logic [7:0] ev;
    int cyc;
    lvl = top_level(rq);
    @(negedge clk);
    irq_n = rq; mask_i = m; dtack_n = 1'b1; vpa_n = 1'b1; data_i = dv;
    @(posedge clk);
    @(negedge clk);
    if (!accepts(lvl, m)) begin
      chk(fc_o == 3'b000, "R2 postponed fc", fc_o, 0);
      chk(sr_wr_o == 1'b0, "R2 postponed sr_wr", sr_wr_o, 0);
      irq_n = 7'h7F;
      return;
    end
    chk(fc_o == 3'b111, "R4 fc in ack", fc_o, 7);
    chk(addr_o == lvl, "R1 addr level", addr_o, lvl);
    chk(sr_wr_o && sr_super_o && sr_mask_o == lvl, "R3 status update", sr_mask_o, lvl);
    // disturb requests and mask while acknowledging
    irq_n = 7'($urandom); mask_i = 3'($urandom);
    cyc = 1;
    if (kind == 3) begin
      while (!done_o && cyc < TMO + 4) begin
        @(posedge clk); @(negedge clk);
        if (fc_o == 3'b111) begin
          cyc++;
          chk(addr_o == lvl, "R9 level held", addr_o, lvl);
        end
      end
      chk(cyc == TMO, "R7 timeout length", cyc, TMO);
      ev = 8'd24;
    end else begin
      for (int d = 0; d < delay; d++) begin
        @(posedge clk); @(negedge clk);
        chk(fc_o == 3'b111 && addr_o == lvl, "R9 ack held", addr_o, lvl);
        chk(sr_wr_o == 1'b0, "R3 single strobe", sr_wr_o, 0);
      end
      dtack_n = !(kind == 0 || kind == 2);
      vpa_n   = !(kind == 1 || kind == 2);
      @(posedge clk); @(negedge clk);
      dtack_n = 1'b1; vpa_n = 1'b1;
      ev = (kind == 1) ? 8'd24 + 8'(lvl) : dv;
    end
    irq_n = 7'h7F;
    chk(done_o == 1'b1, "R10 done", done_o, 1);
    chk(fc_o == 3'b000, "R10 fc released", fc_o, 0);
    if (kind == 2) chk(vec_o == ev, "R8 data over auto", vec_o, ev);
    else if (kind == 1) chk(vec_o == ev, "R6 autovector", vec_o, ev);
    else if (kind == 3) chk(vec_o == ev, "R7 spurious", vec_o, ev);
    else chk(vec_o == ev, "R5 data vector", vec_o, ev);
    chk(vec_addr_o == {ev, 2'b00}, "R5 table address", vec_addr_o, {ev, 2'b00});
    @(posedge clk); @(negedge clk);
    chk(done_o == 1'b0, "R10 done one cycle", done_o, 0);
  endtask

  initial begin
    #1500000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; irq_n = 7'h7F; mask_i = 3'd0;
    dtack_n = 1'b1; vpa_n = 1'b1; data_i = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fc_o == 3'b000 && done_o == 1'b0 && sr_wr_o == 1'b0, "R4 reset state", fc_o, 0);
    rst_n = 1'b1;
    // R1 no request: nothing starts
    run_case(7'h7F, 3'd0, 0, 0, 8'h40);
    // R1 highest active line wins (levels 2 and 5 -> 5)
    run_case(7'b1101101, 3'd0, 0, 1, 8'h82);
    // R2 equal to mask is postponed, greater is taken
    run_case(7'b1111011, 3'd3, 0, 0, 8'h11);
    run_case(7'b1110111, 3'd3, 1, 2, 8'h00);
    // R2 level 7 taken under mask 7
    run_case(7'b0111111, 3'd7, 1, 0, 8'h00);
    // R6 level 1 autovector
    run_case(7'b1111110, 3'd0, 1, 0, 8'h00);
    // R8 both strobes together
    run_case(7'b1111101, 3'd0, 2, 1, 8'hC4);
    // R7 silent bus
    run_case(7'b1011111, 3'd1, 3, 0, 8'h00);
    // R7 boundary: data arrives in the last permitted cycle
    run_case(7'b1111011, 3'd0, 0, TMO - 1, 8'hFF);
    for (int k = 0; k < 60; k++) begin
      run_case(7'($urandom), 3'($urandom), int'($urandom_range(0, 3)),
               int'($urandom_range(0, 4)), 8'($urandom));
    end
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule